// File: doc/BRIEF.md
# Threshold-Network Tile-Reduction Multiplier

This block multiplies two unsigned operands and returns the full-width product one clock after an input strobe. The core is combinational. Every bit of the multiplicand is ANDed with each multiplier bit, and each resulting row is shifted left by the position of its multiplier bit. This builds the partial-product matrix.

The matrix is cut into tiles, each at most four rows high and two columns wide. Each tile drives a small weighted counter. In a tile, bits in the lower column count once and bits in the upper column count twice. The counter's four result bits come from a two-level threshold network: the first level compares the weighted sum against every possible threshold, and the second level picks out the sum intervals in which a given result bit is one. No carry travels between tiles. Result words are dealt into alternating rows of the next matrix so that no two words share a position in a row.

Two such reduction passes leave two operands. A carry-lookahead adder sums them into the product, which is registered together with a valid flag.

Top module: `tms_multiplier`

## Requirements
- R1: One cycle after a cycle with `in_valid` high, `product` equals the unsigned product of the `a_in` and `b_in` sampled in that cycle, for every operand pair.
- R2: `out_valid` is high in exactly the cycles that follow a cycle in which `in_valid` was high.
- R3: `product` keeps its value through any cycle in which `in_valid` is low, whatever the operands carry.
- R4: While `rst_n` is low, and after reset until the first strobe, `out_valid` is 0 and `product` is 0.
- R5: A tile's weighted sum counts each lower-column bit as 1 and each upper-column bit as 2, so the sum lies in 0..12. Its 4-bit binary result is placed at the tile's lower column.
- R6: Each tile result bit is formed in two levels. Threshold units assert when the weighted sum is at least k, for k = 0..13. Interval detectors then mark the single k where unit k is set and unit k+1 is clear. Exactly one interval is marked for any input.
- R7: The bits of the final two operands above the product width, and the adder's carry-out, are always zero. Truncating to the product width therefore loses nothing.
- R8: Boundary operands give exact results: a zero operand gives 0, and both operands at their maximum give the maximum product (65025 for 8-bit operands).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand strobe; enables the output register |
| a_in | input | W (8) | Multiplicand, unsigned |
| b_in | input | W (8) | Multiplier, unsigned |
| out_valid | output | 1 | High one cycle after a strobe |
| product | output | 2W (16) | Registered unsigned product |

## Verification
The clocked properties assume that `in_valid` is low in the cycle in which reset releases. Under that assumption, the one-cycle relation between strobe and valid holds from the first edge. The stimulus meets it by holding `in_valid` and both operands at zero for the whole of reset and one cycle beyond. After that it changes inputs only midway between clock edges.

The spill and interval properties assume that operands are always known values. The bench drives every operand pair explicitly and leaves no input undriven.

// File: rtl/tms_pkg.sv
package tms_pkg;
  localparam int TILE_ROWS = 4;
  localparam int TILE_COLS = 2;
  localparam int TILE_SW   = 4;

  function automatic int rows_after(input int rows_in);
    return 2 * ((rows_in + TILE_ROWS - 1) / TILE_ROWS);
  endfunction
endpackage

// File: rtl/tms_tile_counter.sv
module tms_tile_counter
  import tms_pkg::*;
#(
  parameter int H = TILE_ROWS
) (
  input  logic [H-1:0]       lo_col,
  input  logic [H-1:0]       hi_col,
  output logic [TILE_SW-1:0] word
);
  localparam int SMAX = 3 * H;

  logic [TILE_SW-1:0]            wsum;
  logic [SMAX+1:0]               ge;
  logic [SMAX:0]                 band;
  logic [TILE_SW-1:0][SMAX:0]    pick;

  // weighted input of every first-level unit: lower column 1, upper column 2
  always_comb begin
    wsum = '0;
    for (int i = 0; i < H; i++) begin
      wsum = wsum + TILE_SW'(lo_col[i]) + TILE_SW'({hi_col[i], 1'b0});
    end
  end

  // level 1: threshold units
  for (genvar k = 0; k <= SMAX + 1; k++) begin : g_thr
    assign ge[k] = (wsum >= TILE_SW'(k));
  end

  // level 2: interval detectors, then the bits that are set in each interval
  for (genvar v = 0; v <= SMAX; v++) begin : g_band
    assign band[v] = ge[v] & ~ge[v+1];
    for (genvar n = 0; n < TILE_SW; n++) begin : g_bit
      if (((v >> n) & 1) == 1) begin : g_on
        assign pick[n][v] = band[v];
      end else begin : g_off
        assign pick[n][v] = 1'b0;
      end
    end
  end

  for (genvar n = 0; n < TILE_SW; n++) begin : g_word
    assign word[n] = |pick[n];
  end

  // R6: monotone thresholds leave exactly one interval marked
  always_comb begin
    p_one_band_r6: assert ($onehot(band));
  end
endmodule

// File: rtl/tms_reduce_stage.sv
module tms_reduce_stage
  import tms_pkg::*;
#(
  parameter int ROWS_IN = 8,
  parameter int COLS_IN = 16
) (
  input  logic [ROWS_IN-1:0][COLS_IN-1:0]                   m_in,
  output logic [rows_after(ROWS_IN)-1:0][COLS_IN+1:0]       m_out
);
  localparam int NGRP     = (ROWS_IN + TILE_ROWS - 1) / TILE_ROWS;
  localparam int NPAIR    = COLS_IN / TILE_COLS;
  localparam int ROWS_OUT = rows_after(ROWS_IN);
  localparam int COLS_OUT = COLS_IN + 2;

  logic [NGRP*TILE_ROWS-1:0][COLS_IN-1:0] padded;
  logic [NGRP-1:0][NPAIR-1:0][TILE_SW-1:0] tw;

  for (genvar r = 0; r < NGRP * TILE_ROWS; r++) begin : g_pad
    if (r < ROWS_IN) begin : g_real
      assign padded[r] = m_in[r];
    end else begin : g_zero
      assign padded[r] = '0;
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    for (genvar k = 0; k < NPAIR; k++) begin : g_pair
      logic [TILE_ROWS-1:0] lo, hi;
      for (genvar r = 0; r < TILE_ROWS; r++) begin : g_tap
        assign lo[r] = padded[g*TILE_ROWS + r][2*k];
        assign hi[r] = padded[g*TILE_ROWS + r][2*k + 1];
      end
      tms_tile_counter #(.H(TILE_ROWS)) u_tile (
        .lo_col(lo),
        .hi_col(hi),
        .word  (tw[g][k])
      );
    end
  end

  // even pairs fill one row, odd pairs the next: words never share a column
  always_comb begin
    m_out = '0;
    for (int g = 0; g < NGRP; g++) begin
      for (int k = 0; k < NPAIR; k++) begin
        for (int b = 0; b < TILE_SW; b++) begin
          m_out[2*g + (k % 2)][2*k + b] = tw[g][k][b];
        end
      end
    end
  end

  if (ROWS_OUT != 2 * NGRP || COLS_OUT != 2 * NPAIR + 2) begin : g_shape_bad
    logic unused_shape;
    assign unused_shape = 1'b0;
  end
endmodule

// File: rtl/tms_cla_adder.sv
module tms_cla_adder #(
  parameter int N = 16
) (
  input  logic [N-1:0] x,
  input  logic [N-1:0] y,
  output logic [N-1:0] sum,
  output logic         cout
);
  logic [N-1:0] gen, prop;
  logic [N:0]   carry;

  assign gen  = x & y;
  assign prop = x ^ y;

  // each carry as a flat sum of generate terms gated by propagate runs
  always_comb begin
    logic c, t;
    carry[0] = 1'b0;
    for (int i = 0; i < N; i++) begin
      c = 1'b0;
      for (int j = 0; j <= i; j++) begin
        t = gen[j];
        for (int k = j + 1; k <= i; k++) begin
          t = t & prop[k];
        end
        c = c | t;
      end
      carry[i+1] = c;
    end
  end

  assign sum  = prop ^ carry[N-1:0];
  assign cout = carry[N];
endmodule

// File: rtl/tms_multiplier.sv
module tms_multiplier
  import tms_pkg::*;
#(
  parameter int W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [W-1:0]   a_in,
  input  logic [W-1:0]   b_in,
  output logic           out_valid,
  output logic [2*W-1:0] product
);
  localparam int PW = 2 * W;
  localparam int R1 = rows_after(W);
  localparam int C1 = PW + 2;
  localparam int R2 = rows_after(R1);
  localparam int C2 = C1 + 2;

  logic [W-1:0][PW-1:0]  pp;
  logic [R1-1:0][C1-1:0] m1;
  logic [R2-1:0][C2-1:0] m2;
  logic [PW-1:0]         sum_w;
  logic                  sum_co;
  logic [PW-1:0]         prod_d, prod_q;
  logic                  valid_d, valid_q;

  for (genvar i = 0; i < W; i++) begin : g_pp
    assign pp[i] = b_in[i] ? (PW'(a_in) << i) : '0;
  end

  tms_reduce_stage #(.ROWS_IN(W), .COLS_IN(PW)) u_stage1 (
    .m_in (pp),
    .m_out(m1)
  );

  tms_reduce_stage #(.ROWS_IN(R1), .COLS_IN(C1)) u_stage2 (
    .m_in (m1),
    .m_out(m2)
  );

  tms_cla_adder #(.N(PW)) u_cla (
    .x   (m2[0][PW-1:0]),
    .y   (m2[R2-1][PW-1:0]),
    .sum (sum_w),
    .cout(sum_co)
  );

  // next state
  always_comb begin
    valid_d = in_valid;
    prod_d  = prod_q;
    if (in_valid) prod_d = sum_w;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      prod_q  <= '0;
    end else begin
      valid_q <= valid_d;
      prod_q  <= prod_d;
    end
  end

  assign out_valid = valid_q;
  assign product   = prod_q;

  p_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (product == ($past(a_in) * $past(b_in))));
  p_valid_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  p_valid_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(product));
  p_no_spill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> (!sum_co && m2[0][C2-1:PW] == '0 && m2[R2-1][C2-1:PW] == '0));
endmodule

// File: tb/tms_multiplier_bench.sv
module tms_multiplier_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [W-1:0]   a_in, b_in;
  logic           out_valid;
  logic [2*W-1:0] product;

  int    n_run  = 0;
  int    n_fail = 0;
  bit    checking = 0;
  bit    done = 0;
  string tag_now = "R1";

  // reference model state
  int unsigned exp_prod = 0;
  bit          exp_valid = 0;
  string       cyc_tag = "R4";

  tms_multiplier #(.W(W)) u_tms_multiplier (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .a_in     (a_in),
    .b_in     (b_in),
    .out_valid(out_valid),
    .product  (product)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input int unsigned act, input int unsigned exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_prod  = 0;
      exp_valid = 0;
      cyc_tag   = "R4";
    end else begin
      exp_valid = in_valid;
      if (in_valid) begin
        exp_prod = int'(a_in) * int'(b_in);
        cyc_tag  = tag_now;
      end else begin
        cyc_tag = "R3";
      end
    end
  end

  always @(negedge clk) begin
    if (checking) begin
      check("R2", 32'(out_valid), 32'(exp_valid));
      check(cyc_tag, 32'(product), exp_prod);
    end
  end

  task automatic send(input int unsigned a, input int unsigned b, input string tag);
    @(negedge clk);
    a_in     = W'(a);
    b_in     = W'(b);
    in_valid = 1'b1;
    tag_now  = tag;
  endtask

  task automatic idle(input int unsigned a, input int unsigned b);
    @(negedge clk);
    a_in     = W'(a);
    b_in     = W'(b);
    in_valid = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    a_in     = '0;
    b_in     = '0;
    repeat (3) @(negedge clk);
    check("R4", 32'(out_valid), 0);
    check("R4", 32'(product), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R4", 32'(out_valid), 0);
    check("R4", 32'(product), 0);
    checking = 1;

    // R1: every operand pair
    for (int ai = 0; ai < (1 << W); ai++) begin
      for (int bi = 0; bi < (1 << W); bi++) begin
        send(ai, bi, (ai == 0 || bi == 0) ? "R8" : "R1");
      end
    end

    // R3: operands move while the strobe is low
    send(200, 77, "R1");
    idle(13, 250);
    idle(255, 255);
    idle(0, 0);

    // R2: alternating strobe
    send(3, 5, "R2");
    idle(9, 9);
    send(17, 33, "R2");
    idle(100, 100);

    // R5: full tiles (upper and lower columns saturated)
    send(255, 15, "R5");
    send(15, 255, "R5");
    send(170, 85, "R5");
    // R6: sums landing on every interval edge
    send(1, 1, "R6");
    send(3, 3, "R6");
    send(7, 7, "R6");
    send(12, 240, "R6");
    // R7: products at the top of the range
    send(255, 254, "R7");
    send(255, 255, "R7");
    // R8: boundaries
    send(0, 255, "R8");
    send(255, 0, "R8");
    send(255, 255, "R8");
    send(1, 255, "R8");

    idle(0, 0);
    idle(0, 0);
    @(negedge clk);
    checking = 0;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end
endmodule